// File: doc/BRIEF.md
# Blink and Breathe LED Controller

This block drives one LED pin from a small set of software-written registers. It has four modes. Off holds the pin low and on holds it high. Blink produces a fixed-duty square wave from an 8-bit PWM counter with a prescaler. Breathe makes the duty ramp up and down between a programmed floor and ceiling. The ramp pauses at each end and moves by a programmed step at a programmed pace. A single PWM engine serves both the blink and breathe modes.

The PWM time base advances on every clock or only on a slow tick strobe, as a control bit selects. The slow strobe is a one-clock pulse at 32.768 kHz from outside the block. New level and delay values are written to shadow registers and only go live through an update handshake. This keeps a visible period from ever mixing old and new settings. A sync input restarts the counters so that several instances can line up their waveforms. An interrupt line pulses once per breathing cycle.

Top module: `blink_breathe_led`

## Requirements
- R1: The mode field is control bits [1:0], coded 0 = off, 1 = breathe, 2 = blink, 3 = on. Off drives the pin low and on drives it high. Reset leaves every register at 0, so the block starts in off mode.
- R2: In blink mode the pin is high while the 8-bit PWM counter is below the floor field (limits bits [7:0]). Each period therefore has floor × (prescaler + 1) high time-base ticks.
- R3: In blink mode one PWM period lasts 256 × (prescaler + 1) time-base ticks. The prescaler is delay bits [11:0].
- R4: Control bit 2 picks the time base. When it is set the base advances on every clock. When it is clear the base advances only on clocks where `tick_slow` is high.
- R5: In breathe mode the period is 2^(6+w) ticks, where w is the width code in control bits [10:8]. The duty is level/256. The level starts at the floor. At each step it rises by the step register (bits [7:0], 0 acts as 1), one step every interval+1 periods (interval register bits [7:0]). Once it reaches the ceiling (limits bits [15:8]) it holds there, then falls the same way to the floor.
- R6: The hold at the floor lasts low-delay+1 periods (delay bits [11:0]). The hold at the ceiling lasts high-delay+1 periods (delay bits [23:12]) when the asymmetric bit (control bit 4) is set. When that bit is clear, the ceiling hold uses the low delay as well.
- R7: `irq` is high for exactly one clock each time the falling ramp lands on the floor, and never outside breathe mode.
- R8: Writes to limits and delay land in shadow copies and read back at once, but they do not change the waveform. Setting control bit 5 requests an update. The bit reads 1 until the shadow copies go live, then reads 0. They go live at the end of the current PWM period in blink or breathe mode, and on the next clock in off or on mode.
- R9: A write to the width code is ignored while the mode is breathe or blink, and codes above 6 are always ignored.
- R10: A control write with bit 6 set discards the rest of the written value and returns every register to 0.
- R11: When control bit 3 is set, a high `sync_pulse` restarts the PWM counter at zero. When the bit is clear, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_slow | input | 1 | One-clock strobe at 32.768 kHz, the slow time base |
| sync_pulse | input | 1 | Counter restart request shared across instances |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 control, 1 limits, 2 delay, 3 step, 4 interval |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read select, same coding as wr_sel |
| rd_data | output | 32 | Read data (combinational) |
| pwm_out | output | 1 | LED pin |
| irq | output | 1 | One-clock pulse when the breathe ramp reaches the floor |

## Verification
A wrong counter bound or prescaler compare shows at the pin within one PWM period. It appears as a changed count of high clocks per period or a changed spacing of rising edges. A wrong ramp phase, delay choice or step shows one breathing cycle later. It changes both the clock count and the high-clock count between two interrupt pulses, and these totals are fixed by the level sequence. A fault in the update handshake or in the width lock shows in register readback within a few clocks, or in the duty of the first period after the update should have landed.

// File: rtl/lbb_pkg.sv
// Shared constants and types for the blink/breathe LED controller.
// Assumes a 32-bit register data path; all other sizes derive from here.
package lbb_pkg;
    localparam int DATA_W       = 32;
    localparam int SEL_W        = 3;
    localparam int LVL_W        = 8;
    localparam int DLY_W        = 12;
    localparam int STEP_W       = 8;
    localparam int WCODE_W      = 3;
    localparam int PWM_MIN_BITS = 6;
    localparam int WIDTH_MAX    = 6;
    localparam int CNT_W        = PWM_MIN_BITS + WIDTH_MAX;

    // register selects
    localparam logic [SEL_W-1:0] SEL_CTL   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_LIM   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DLY   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STEP  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IVAL  = 3'd4;

    // control bit positions
    localparam int B_FAST  = 2;
    localparam int B_SYNC  = 3;
    localparam int B_ASYM  = 4;
    localparam int B_UPD   = 5;
    localparam int B_SRST  = 6;
    localparam int B_WIDTH = 8;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_BREATHE = 2'd1,
        MODE_BLINK   = 2'd2,
        MODE_ON      = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        PH_HOLD_LO, PH_RISE, PH_HOLD_HI, PH_FALL
    } phase_t;
endpackage

// File: rtl/lbb_regs.sv
// Register file: control word, shadow and live limit/delay copies, step
// and interval. Shadow copies go live through the update handshake.
// Assumes period_end is a one-clock strobe from the PWM engine.
module lbb_regs
    import lbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               period_end,
    output mode_t              mode,
    output logic               clk_fast,
    output logic               sync_en,
    output logic               asym,
    output logic [WCODE_W-1:0] width,
    output logic               upd_pending,
    output logic [LVL_W-1:0]   min_l,
    output logic [LVL_W-1:0]   max_l,
    output logic [DLY_W-1:0]   lo_l,
    output logic [DLY_W-1:0]   hi_l,
    output logic [STEP_W-1:0]  step,
    output logic [STEP_W-1:0]  ival
);
    logic [LVL_W-1:0] min_s, max_s;
    logic [DLY_W-1:0] lo_s, hi_s;
    logic             ctl_wr, srst_wr, busy, idle;
    logic [WCODE_W-1:0] new_width;
    logic [DATA_W-1:0]  unused_wr_bits;

    assign ctl_wr    = wr_en && (wr_sel == SEL_CTL);
    assign srst_wr   = ctl_wr && wr_data[B_SRST];
    assign busy      = (mode == MODE_BREATHE) || (mode == MODE_BLINK);
    assign idle      = !busy;
    assign new_width = wr_data[B_WIDTH +: WCODE_W];
    assign unused_wr_bits = wr_data;

    // Register state: reset, soft reset, writes and the update handshake
    always_ff @(posedge clk) begin
        if (!rst_n || srst_wr) begin
            mode <= MODE_OFF;  clk_fast <= 1'b0; sync_en <= 1'b0; asym <= 1'b0;
            width <= '0;       upd_pending <= 1'b0;
            min_s <= '0; max_s <= '0; lo_s <= '0; hi_s <= '0;
            min_l <= '0; max_l <= '0; lo_l <= '0; hi_l <= '0;
            step <= '0;  ival <= '0;
        end else begin
            if (upd_pending && (period_end || idle)) begin
                min_l <= min_s; max_l <= max_s; lo_l <= lo_s; hi_l <= hi_s;
                upd_pending <= 1'b0;
            end
            if (ctl_wr) begin
                mode     <= mode_t'(wr_data[1:0]);
                clk_fast <= wr_data[B_FAST];
                sync_en  <= wr_data[B_SYNC];
                asym     <= wr_data[B_ASYM];
                if (!busy && (int'(new_width) <= WIDTH_MAX))
                    width <= new_width;
                if (wr_data[B_UPD])
                    upd_pending <= 1'b1;
            end
            if (wr_en && (wr_sel == SEL_LIM)) begin
                min_s <= wr_data[LVL_W-1:0];
                max_s <= wr_data[2*LVL_W-1:LVL_W];
            end
            if (wr_en && (wr_sel == SEL_DLY)) begin
                lo_s <= wr_data[DLY_W-1:0];
                hi_s <= wr_data[2*DLY_W-1:DLY_W];
            end
            if (wr_en && (wr_sel == SEL_STEP)) step <= wr_data[STEP_W-1:0];
            if (wr_en && (wr_sel == SEL_IVAL)) ival <= wr_data[STEP_W-1:0];
        end
    end

    // Read mux: control word with live handshake bit, shadow copies
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTL: begin
                rd_data[1:0]                 = mode;
                rd_data[B_FAST]              = clk_fast;
                rd_data[B_SYNC]              = sync_en;
                rd_data[B_ASYM]              = asym;
                rd_data[B_UPD]               = upd_pending;
                rd_data[B_WIDTH +: WCODE_W]  = width;
            end
            SEL_LIM:  rd_data[2*LVL_W-1:0] = {max_s, min_s};
            SEL_DLY:  rd_data[2*DLY_W-1:0] = {hi_s, lo_s};
            SEL_STEP: rd_data[STEP_W-1:0]  = step;
            SEL_IVAL: rd_data[STEP_W-1:0]  = ival;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lbb_pwm.sv
// PWM engine shared by blink and breathe. Blink: prescaled 8-bit counter.
// Breathe: counter of 6+width bits, no prescaler. Counters clear on a mode
// change, on a restart, and whenever the mode is off or on.
module lbb_pwm
    import lbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  mode_t              mode,
    input  logic               tb_en,
    input  logic               restart,
    input  logic [DLY_W-1:0]   pre,
    input  logic [WCODE_W-1:0] width,
    output logic [CNT_W-1:0]   cnt,
    output logic               period_end
);
    localparam logic [CNT_W-1:0] BLINK_TOP = CNT_W'({LVL_W{1'b1}});

    mode_t            mode_q;
    logic [DLY_W-1:0] pre_cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] top;
    logic             blink, running, pre_done, adv;

    assign blink    = (mode == MODE_BLINK);
    assign running  = blink || (mode == MODE_BREATHE);
    assign span     = ({{CNT_W{1'b0}}, 1'b1} << (PWM_MIN_BITS + int'(width))) - 1'b1;
    assign top      = blink ? BLINK_TOP : span[CNT_W-1:0];
    assign pre_done = !blink || (pre_cnt >= pre);
    assign adv      = tb_en && pre_done;
    assign period_end = running && adv && (cnt == top) && !restart && (mode == mode_q);

    // Counter and prescaler advance on the selected time base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF; cnt <= '0; pre_cnt <= '0;
        end else begin
            mode_q <= mode;
            if (restart || (mode != mode_q) || !running) begin
                cnt <= '0; pre_cnt <= '0;
            end else if (tb_en) begin
                if (!pre_done) begin
                    pre_cnt <= pre_cnt + 1'b1;
                end else begin
                    pre_cnt <= '0;
                    cnt     <= (cnt == top) ? '0 : cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lbb_ramp.sv
// Breathe ramp: hold at floor, rise, hold at ceiling, fall, once per
// cycle; all moves happen at PWM period ends. Pulses irq on landing at
// the floor. Idles at the live floor level while not active.
module lbb_ramp
    import lbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              period_end,
    input  logic [LVL_W-1:0]  min_l,
    input  logic [LVL_W-1:0]  max_l,
    input  logic [DLY_W-1:0]  lo_l,
    input  logic [DLY_W-1:0]  hi_l,
    input  logic              asym,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] ival,
    output logic [LVL_W-1:0]  level,
    output logic              irq
);
    phase_t           ph;
    logic [DLY_W-1:0] wait_cnt, hi_hold, ival_x;
    logic [LVL_W:0]   step_eff, up_sum, dn_lim;
    logic             reach_max, reach_min;

    assign step_eff  = (step == '0) ? (LVL_W+1)'(1) : (LVL_W+1)'(step);
    assign hi_hold   = asym ? hi_l : lo_l;
    assign ival_x    = DLY_W'(ival);
    assign up_sum    = {1'b0, level} + step_eff;
    assign dn_lim    = {1'b0, min_l} + step_eff;
    assign reach_max = up_sum >= {1'b0, max_l};
    assign reach_min = {1'b0, level} <= dn_lim;

    // Phase, level and wait counter, stepped at PWM period ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_HOLD_LO; level <= '0; wait_cnt <= '0; irq <= 1'b0;
        end else if (!active) begin
            ph <= PH_HOLD_LO; level <= min_l; wait_cnt <= '0; irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (period_end) begin
                case (ph)
                    PH_HOLD_LO:
                        if (wait_cnt >= lo_l) begin ph <= PH_RISE; wait_cnt <= '0; end
                        else wait_cnt <= wait_cnt + 1'b1;
                    PH_RISE:
                        if (wait_cnt >= ival_x) begin
                            wait_cnt <= '0;
                            if (reach_max) begin level <= max_l; ph <= PH_HOLD_HI; end
                            else level <= up_sum[LVL_W-1:0];
                        end else wait_cnt <= wait_cnt + 1'b1;
                    PH_HOLD_HI:
                        if (wait_cnt >= hi_hold) begin ph <= PH_FALL; wait_cnt <= '0; end
                        else wait_cnt <= wait_cnt + 1'b1;
                    default:
                        if (wait_cnt >= ival_x) begin
                            wait_cnt <= '0;
                            if (reach_min) begin
                                level <= min_l; ph <= PH_HOLD_LO; irq <= 1'b1;
                            end else level <= level - step_eff[LVL_W-1:0];
                        end else wait_cnt <= wait_cnt + 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/blink_breathe_led.sv
// Top of the blink/breathe LED controller: registers, shared PWM engine,
// breathe ramp and pin selection. Assumes tick_slow is a one-clock strobe
// synchronous to clk; the pin is a combinational decode of registers.
module blink_breathe_led
    import lbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              sync_pulse,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              irq
);
    mode_t               mode;
    logic                clk_fast, sync_en, asym, upd_pending, period_end;
    logic [WCODE_W-1:0]  width;
    logic [LVL_W-1:0]    min_l, max_l, level;
    logic [DLY_W-1:0]    lo_l, hi_l;
    logic [STEP_W-1:0]   step, ival;
    logic [CNT_W-1:0]    cnt, duty_ext;

    lbb_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .period_end(period_end),
        .mode(mode), .clk_fast(clk_fast), .sync_en(sync_en), .asym(asym),
        .width(width), .upd_pending(upd_pending),
        .min_l(min_l), .max_l(max_l), .lo_l(lo_l), .hi_l(hi_l),
        .step(step), .ival(ival)
    );

    lbb_pwm u_pwm (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .tb_en(clk_fast || tick_slow), .restart(sync_en && sync_pulse),
        .pre(lo_l), .width(width), .cnt(cnt), .period_end(period_end)
    );

    lbb_ramp u_ramp (
        .clk(clk), .rst_n(rst_n), .active(mode == MODE_BREATHE),
        .period_end(period_end), .min_l(min_l), .max_l(max_l),
        .lo_l(lo_l), .hi_l(hi_l), .asym(asym), .step(step), .ival(ival),
        .level(level), .irq(irq)
    );

    // Scale the 8-bit level onto a counter of 6+width bits
    assign duty_ext = {level, {(CNT_W-LVL_W){1'b0}}} >> (WIDTH_MAX - int'(width));

    // Pin decode per mode
    always_comb begin
        case (mode)
            MODE_OFF:    pwm_out = 1'b0;
            MODE_ON:     pwm_out = 1'b1;
            MODE_BLINK:  pwm_out = cnt[LVL_W-1:0] < min_l;
            default:     pwm_out = cnt < duty_ext;
        endcase
    end
endmodule

// File: rtl/lbb_checker.sv
// Protocol checker for blink_breathe_led, attached by bind below.
module lbb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       pwm_out,
    input logic       irq,
    input logic       upd_pending,
    input logic       period_end,
    input logic [2:0] width,
    input logic       srst_req
);
    // R1: off mode holds the pin low
    a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !pwm_out);
    // R1: on mode holds the pin high
    a_r1_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> pwm_out);
    // R7: interrupt lasts a single clock
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7: interrupt comes only from breathe mode
    a_r7_irq_breathe: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(mode) == 2'd1));
    // R8: the update bit drops only at a period end, in off/on, or by soft reset
    a_r8_upd_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pending) |-> ($past(period_end) || $past(mode) == 2'd0 ||
                                $past(mode) == 2'd3 || $past(srst_req)));
    // R9: width is locked while blink or breathe runs
    a_r9_width_lock: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1) || (mode == 2'd2)) && !srst_req |=> $stable(width));
endmodule

bind blink_breathe_led lbb_checker i_lbb_checker (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwm_out(pwm_out), .irq(irq),
    .upd_pending(upd_pending), .period_end(period_end), .width(width),
    .srst_req(wr_en && (wr_sel == 3'd0) && wr_data[6])
);

// File: tb/test_blink_breathe_led.sv
// Scoreboard bench: measuring tasks queue expected and observed values,
// a monitor process pops and compares them.
module test_blink_breathe_led;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, tick_slow = 1'b0, sync_pulse = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        pwm_out, irq;
    int          checks = 0, errors = 0, tdiv = 0;
    bit          tick_run = 1'b0, done = 1'b0;
    int          exp_q[$];
    int          act_q[$];
    string       tag_q[$];

    localparam int FAST = 4, SYNC = 8, ASYM = 16, UPD = 32, SRST = 64;

    always #2 clk = ~clk;

    blink_breathe_led i_blink_breathe_led (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .sync_pulse(sync_pulse),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
    );

    // slow tick strobe every fourth clock
    always @(negedge clk) begin
        if (tick_run) begin
            tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
            tick_slow <= (tdiv == 3);
        end else tick_slow <= 1'b0;
    end

    // monitor: compare queued items
    always @(negedge clk) begin
        int e; int a; string t;
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (e != a) begin
                errors++;
                $display("FAIL %s actual %0d expected %0d", t, a, e);
            end
        end
    end

    task automatic post(input string t, input int e, input int a);
        tag_q.push_back(t); exp_q.push_back(e); act_q.push_back(a);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk); rd_sel = s; #1 v = rd_data;
    endtask

    task automatic count_win(input int n, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0; prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    task automatic ramp_cycle(output int cyc, output int hi);
        do @(negedge clk); while (!irq);
        cyc = 0; hi = 0;
        do begin
            cyc++; if (pwm_out) hi++;
            @(negedge clk);
        end while (!irq);
    endtask

    task automatic wait_upd();
        logic [31:0] v;
        do rd(3'd0, v); while (v[5]);
    endtask

    initial begin
        logic [31:0] v;
        int hi, rs, cyc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, v);
        post("R1 reset ctl", 0, int'(v));
        post("R1 reset pin", 0, int'(pwm_out));
        post("R7 reset irq", 0, int'(irq));

        wr(3'd0, 3 | FAST);
        post("R1 on pin", 1, int'(pwm_out));
        wr(3'd0, 0);
        post("R1 off pin", 0, int'(pwm_out));

        // blink, duty 64, prescaler 0
        wr(3'd1, 32'h0000_0040);
        wr(3'd2, 0);
        wr(3'd0, UPD);
        @(negedge clk);
        wr(3'd0, 2 | FAST);
        repeat (300) @(negedge clk);
        count_win(256, hi, rs);
        post("R2 blink high per period", 64, hi);

        // prescaler 1 via update while blinking
        wr(3'd2, 1);
        wr(3'd0, 2 | FAST | UPD);
        rd(3'd0, v);
        post("R8 update pending", 1, int'(v[5]));
        wait_upd();
        count_win(1024, hi, rs);
        post("R3 period 512 rises", 2, rs);
        post("R2 high with prescaler", 256, hi);

        // R4 slow time base
        tick_run = 1'b1;
        wr(3'd0, 2);
        repeat (100) @(negedge clk);
        count_win(2048, hi, rs);
        post("R4 slow high", 512, hi);
        post("R4 slow rises", 1, rs);
        tick_run = 1'b0;

        // R8 staging: prescaler 0 and duty 128 staged
        wr(3'd0, 0);
        wr(3'd2, 0);
        wr(3'd0, UPD);
        @(negedge clk);
        wr(3'd0, 2 | FAST);
        wr(3'd1, 32'h0000_0080);
        rd(3'd1, v);
        post("R8 shadow readback", 128, int'(v[15:0]));
        repeat (20) @(negedge clk);
        count_win(256, hi, rs);
        post("R8 staged value not live", 64, hi);
        wr(3'd0, 2 | FAST | UPD);
        wait_upd();
        count_win(256, hi, rs);
        post("R8 live after update", 128, hi);

        // R9 width locked while blinking
        wr(3'd0, 2 | FAST | (5 << 8));
        rd(3'd0, v);
        post("R9 width ignored busy", 0, int'(v[10:8]));
        wr(3'd0, 0 | (7 << 8));
        rd(3'd0, v);
        post("R9 code 7 ignored", 0, int'(v[10:8]));

        // R11 sync restart
        wr(3'd0, 2 | FAST | SYNC);
        do @(negedge clk); while (!pwm_out);
        do @(negedge clk); while (pwm_out);
        sync_pulse = 1'b1;
        @(negedge clk); sync_pulse = 1'b0;
        post("R11 sync restarts counter", 1, int'(pwm_out));
        wr(3'd0, 2 | FAST);
        do @(negedge clk); while (!pwm_out);
        do @(negedge clk); while (pwm_out);
        sync_pulse = 1'b1;
        @(negedge clk); sync_pulse = 1'b0;
        post("R11 sync ignored", 0, int'(pwm_out));

        // breathe: floor 16, ceiling 64, step 16, interval 0, lo 0 hi 3
        wr(3'd0, 0);
        wr(3'd1, 32'h0000_4010);
        wr(3'd2, 32'h0000_3000);
        wr(3'd3, 16);
        wr(3'd4, 0);
        wr(3'd0, UPD);
        @(negedge clk);
        wr(3'd0, 1 | FAST | (2 << 8));
        rd(3'd0, v);
        post("R9 width taken when idle", 2, int'(v[10:8]));
        ramp_cycle(cyc, hi);
        post("R5 breathe cycle clocks", 2048, cyc);
        post("R5 breathe high clocks", 320, hi);
        post("R7 irq one clock", 0, int'(irq === 1'b1 ? 0 : 1));
        @(negedge clk);
        post("R7 irq drops", 0, int'(irq));

        // R6 asymmetric hold at ceiling uses hi delay (3)
        wr(3'd0, 1 | FAST | ASYM | (2 << 8));
        ramp_cycle(cyc, hi);
        post("R6 asym cycle clocks", 2816, cyc);
        post("R6 asym high clocks", 512, hi);

        // R6 floor hold lo 2
        wr(3'd2, 32'h0000_3002);
        wr(3'd0, 1 | FAST | ASYM | UPD | (2 << 8));
        wait_upd();
        ramp_cycle(cyc, hi);
        post("R6 floor hold clocks", 3328, cyc);
        post("R6 floor hold high", 544, hi);

        // R10 soft reset
        wr(3'd0, SRST | 3);
        rd(3'd0, v);
        post("R10 ctl cleared", 0, int'(v));
        rd(3'd1, v);
        post("R10 limits cleared", 0, int'(v));
        post("R10 pin low", 0, int'(pwm_out));

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    // watchdog and summary
    initial begin
        int n;
        n = 0;
        while (!done && n < 150000) begin
            @(posedge clk); n++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected finish", n);
        end
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule